// File: doc/BRIEF.md
# Vectored Interrupt Sequencer

This block sits beside the decoder of a small 8-bit processor core. It collects interrupt requests, chooses one, and steps the core through entering and leaving a service routine. Each source is either edge-type or level-type. An edge-type source latches a flag on a rising request, and that flag is held until it is served or cleared by software. A level-type source has no flag and requests only while its input is high. A request is accepted at an instruction boundary when its own enable and the global enable are both set, when no multi-cycle instruction is in progress, and when the decoder is neither disabling interrupts nor issuing a return in that cycle.

Entry pushes the 16-bit program counter onto the stack as two bytes, low byte first. It then loads the vector address for the chosen source and clears the global enable. If the core was asleep, a fixed wake delay comes before the push. A return pops the two bytes in reverse order, hands the restored counter back to the core and sets the global enable again. At least one instruction of the interrupted program then runs before any pending request is accepted.

The sequencer is a state machine with eight states. IDLE waits for a take or a return. IDLE goes to WAKE on a take while asleep, and to PUSH_LO on a take while awake. WAKE goes to PUSH_LO when its count runs out. PUSH_LO goes to PUSH_HI, and PUSH_HI goes to JUMP. JUMP goes back to IDLE when its count runs out, with the vector load in its last cycle. On a return, IDLE goes to POP_HI. POP_HI goes to POP_LO, and POP_LO goes to RESUME. RESUME goes back to IDLE when its count runs out, with the restore strobe in its last cycle.

Top module: `irq_sequencer`

## Requirements
- R1: A request is taken only at a cycle with `insn_bound_i`=1, `multi_busy_i`=0, `reti_i`=0, the global enable at 1, and the source's enable bit at 1. A latched flag whose enable or global enable is 0 is not taken.
- R2: Taking a request clears the global enable from the next cycle on. A later `gie_set_i` pulse sets it again, and a nested request can then be taken.
- R3: The global enable reads 1 in the cycle after the return sequence's restore strobe.
- R4: For an edge-type source, a rising request sets bit i of `flags_o`, where i is the source index. The bit stays set until its vector is taken (hardware clear) or until a cycle with `flag_clr_wr_i`=1 and bit i of `flag_clr_data_i` at 1. Bit 0 always reads 0.
- R5: A level-type source (bit i of LEVEL_MASK at 1, default sources 6 and 7) never shows a flag. If its request drops before the source is enabled, nothing is taken.
- R6: Among eligible sources, the lowest index is served. Index 0 is reserved for reset and is never taken.
- R7: After a return, the first instruction boundary is ignored for acceptance. A request still pending is taken at the next boundary.
- R8: `gie_clr_i` clears the global enable for the next cycle. No request is taken in the same cycle as `gie_clr_i`.
- R9: When awake, `vec_load_o` pulses in the 4th cycle after the take edge. `push_stb_o` carries the PC low byte in the 1st cycle and the high byte in the 2nd.
- R10: When `sleep_i`=1 at the take, `vec_load_o` pulses in the 8th cycle after the take edge.
- R11: After a return edge there are two `pop_stb_o` cycles, high byte first. `pc_restore_vld_o` pulses in the 4th cycle with the popped PC on `pc_restore_o`.
- R12: `vec_addr_o` equals VEC_BASE plus twice the source index (default base 0).
- R13: `seq_busy_o` is 1 from the cycle after a take or a return edge until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | N | Request lines, one per source |
| src_en_i | input | N | Per-source enables |
| flag_clr_wr_i | input | 1 | Software write strobe for clearing flags |
| flag_clr_data_i | input | N | Ones mark the flags to clear |
| gie_set_i | input | 1 | Software sets the global enable |
| gie_clr_i | input | 1 | Decoder global-disable strobe |
| insn_bound_i | input | 1 | Instruction boundary, where a take is allowed |
| multi_busy_i | input | 1 | A multi-cycle instruction is still running |
| sleep_i | input | 1 | Core is in sleep |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | 16 | Program counter to save |
| pop_data_i | input | 8 | Byte read back from the stack |
| push_stb_o | output | 1 | Push one byte |
| push_data_o | output | 8 | Byte to push |
| pop_stb_o | output | 1 | Pop one byte |
| pc_restore_o | output | 16 | Restored program counter |
| pc_restore_vld_o | output | 1 | Restored counter valid |
| vec_load_o | output | 1 | Load the vector address into the PC |
| vec_addr_o | output | ADDR_W | Vector address |
| gie_o | output | 1 | Global enable state |
| seq_busy_o | output | 1 | Entry or return sequence active |
| flags_o | output | N | Latched edge flags |

## Verification
Inputs are driven one time unit after a rising edge and sampled at the same offset. Cycle k therefore means the value after the k-th edge following the take or return edge. Going by the registers on each path, `vec_load_o` is due at k=4 when awake and at k=8 when asleep. The push bytes are due at k=1 and 2 when awake, the pops at k=1 and 2, and the restore strobe at k=4. The global enable reads 1 at k=5 after a return and reads 0 from k=1 after a take. A flag appears one cycle after its rising request, and both check tasks scan a fixed window after each stimulus, recording the cycle at which each strobe appears. Negative cases hold the boundary for one edge and then watch the same window, so that no take and no busy cycle appears.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int PC_W   = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_JUMP,
        ST_POP_HI,
        ST_POP_LO,
        ST_RESUME
    } seq_state_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int          N          = 8,
    parameter logic [N-1:0] LEVEL_MASK = 8'hC0,
    localparam int         IDX_W      = $clog2(N)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N-1:0]     req_i,
    input  logic             sw_clr_i,
    input  logic [N-1:0]     sw_clr_mask_i,
    input  logic             hw_clr_i,
    input  logic [IDX_W-1:0] hw_clr_idx_i,
    output logic [N-1:0]     flags_o,
    output logic [N-1:0]     pend_o
);
    // Source 0 is reserved; level sources carry no flag.
    localparam logic [N-1:0] RESV_MASK = N'(1);
    localparam logic [N-1:0] EDGE_MASK = ~LEVEL_MASK & ~RESV_MASK;

    logic [N-1:0] req_d;
    logic [N-1:0] rise;
    logic [N-1:0] clr_vec;
    logic [N-1:0] flag_q;
    logic [N-1:0] flag_n;

    always_comb begin
        rise    = req_i & ~req_d;
        clr_vec = (sw_clr_i ? sw_clr_mask_i : '0)
                | (hw_clr_i ? (N'(1) << hw_clr_idx_i) : '0);
        // A new edge wins over a clear in the same cycle.
        flag_n  = ((flag_q & ~clr_vec) | rise) & EDGE_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_d  <= '0;
            flag_q <= '0;
        end else begin
            req_d  <= req_i;
            flag_q <= flag_n;
        end
    end

    assign flags_o = flag_q;
    assign pend_o  = flag_q | (req_i & LEVEL_MASK & ~RESV_MASK);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int  N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend_i,
    input  logic [N-1:0]     en_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N-1:0] cand;

    always_comb begin
        cand  = pend_i & en_i & ~N'(1);
        any_o = |cand;
        idx_o = '0;
        // Scan downward so the lowest eligible index is the one left.
        for (int i = N - 1; i >= 1; i--) begin
            if (cand[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int  N         = 8,
    parameter int  ENTRY_CYC = 4,
    parameter int  WAKE_CYC  = 4,
    parameter int  RET_CYC   = 4,
    localparam int IDX_W     = $clog2(N),
    localparam int MAX_CYC   = (ENTRY_CYC > WAKE_CYC)
                               ? ((ENTRY_CYC > RET_CYC) ? ENTRY_CYC : RET_CYC)
                               : ((WAKE_CYC > RET_CYC) ? WAKE_CYC : RET_CYC),
    localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              any_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              gie_set_i,
    input  logic              gie_clr_i,
    input  logic              bound_i,
    input  logic              busy_i,
    input  logic              sleep_i,
    input  logic              reti_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [BYTE_W-1:0] pop_data_i,
    output logic              take_o,
    output logic              skip_o,
    output logic [IDX_W-1:0]  win_idx_o,
    output logic              gie_o,
    output logic              push_stb_o,
    output logic [BYTE_W-1:0] push_data_o,
    output logic              pop_stb_o,
    output logic [PC_W-1:0]   pc_restore_o,
    output logic              pc_restore_vld_o,
    output logic              vec_load_o,
    output logic              seq_busy_o
);
    seq_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q;
    logic [PC_W-1:0]   pc_q;
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic [IDX_W-1:0]  idx_q;
    logic              gie_q, skip_q;
    logic              take, ret_go, ret_done;

    assign take     = (state_q == ST_IDLE) && bound_i && !busy_i && !reti_i
                      && gie_q && !gie_clr_i && any_i && !skip_q;
    assign ret_go   = (state_q == ST_IDLE) && reti_i;
    assign ret_done = (state_q == ST_RESUME) && (cnt_q == '0);

    // Next-state logic.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ret_go)    state_n = ST_POP_HI;
                else if (take) state_n = sleep_i ? ST_WAKE : ST_PUSH_LO;
            end
            ST_WAKE:    if (cnt_q == '0) state_n = ST_PUSH_LO;
            ST_PUSH_LO: state_n = ST_PUSH_HI;
            ST_PUSH_HI: state_n = ST_JUMP;
            ST_JUMP:    if (cnt_q == '0) state_n = ST_IDLE;
            ST_POP_HI:  state_n = ST_POP_LO;
            ST_POP_LO:  state_n = ST_RESUME;
            ST_RESUME:  if (cnt_q == '0) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State register and sequence data.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pc_q    <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            idx_q   <= '0;
            gie_q   <= 1'b0;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_n != state_q) begin
                unique case (state_n)
                    ST_WAKE:   cnt_q <= CNT_W'(WAKE_CYC - 1);
                    ST_JUMP:   cnt_q <= CNT_W'(ENTRY_CYC - 3);
                    ST_RESUME: cnt_q <= CNT_W'(RET_CYC - 3);
                    default:   cnt_q <= '0;
                endcase
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (take) begin
                pc_q  <= pc_i;
                idx_q <= idx_i;
            end
            if (state_q == ST_POP_HI) hi_q <= pop_data_i;
            if (state_q == ST_POP_LO) lo_q <= pop_data_i;
            if (take || gie_clr_i)          gie_q <= 1'b0;
            else if (gie_set_i || ret_done) gie_q <= 1'b1;
            if (ret_done)                                         skip_q <= 1'b1;
            else if ((state_q == ST_IDLE) && bound_i && !busy_i) skip_q <= 1'b0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        push_stb_o       = 1'b0;
        push_data_o      = '0;
        pop_stb_o        = 1'b0;
        vec_load_o       = 1'b0;
        pc_restore_vld_o = 1'b0;
        unique case (state_q)
            ST_PUSH_LO: begin
                push_stb_o  = 1'b1;
                push_data_o = pc_q[BYTE_W-1:0];
            end
            ST_PUSH_HI: begin
                push_stb_o  = 1'b1;
                push_data_o = pc_q[PC_W-1:BYTE_W];
            end
            ST_JUMP:    vec_load_o = (cnt_q == '0);
            ST_POP_HI,
            ST_POP_LO:  pop_stb_o = 1'b1;
            ST_RESUME:  pc_restore_vld_o = (cnt_q == '0);
            default: ;
        endcase
    end

    assign take_o       = take;
    assign skip_o       = skip_q;
    assign win_idx_o    = idx_q;
    assign gie_o        = gie_q;
    assign pc_restore_o = {hi_q, lo_q};
    assign seq_busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int               N          = 8,
    parameter logic [N-1:0]     LEVEL_MASK = 8'hC0,
    parameter int               ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE  = '0,
    parameter int               ENTRY_CYC  = 4,
    parameter int               WAKE_CYC   = 4,
    parameter int               RET_CYC    = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N-1:0]      irq_req_i,
    input  logic [N-1:0]      src_en_i,
    input  logic              flag_clr_wr_i,
    input  logic [N-1:0]      flag_clr_data_i,
    input  logic              gie_set_i,
    input  logic              gie_clr_i,
    input  logic              insn_bound_i,
    input  logic              multi_busy_i,
    input  logic              sleep_i,
    input  logic              reti_i,
    input  logic [15:0]       pc_i,
    input  logic [7:0]        pop_data_i,
    output logic              push_stb_o,
    output logic [7:0]        push_data_o,
    output logic              pop_stb_o,
    output logic [15:0]       pc_restore_o,
    output logic              pc_restore_vld_o,
    output logic              vec_load_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              gie_o,
    output logic              seq_busy_o,
    output logic [N-1:0]      flags_o
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0]     pend_w;
    logic             any_w;
    logic [IDX_W-1:0] pick_w;
    logic [IDX_W-1:0] win_w;
    logic             take_w;
    logic             skip_w;

    irq_flag_bank #(.N(N), .LEVEL_MASK(LEVEL_MASK)) u_flags (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .req_i         (irq_req_i),
        .sw_clr_i      (flag_clr_wr_i),
        .sw_clr_mask_i (flag_clr_data_i),
        .hw_clr_i      (take_w),
        .hw_clr_idx_i  (pick_w),
        .flags_o       (flags_o),
        .pend_o        (pend_w)
    );

    irq_prio_pick #(.N(N)) u_pick (
        .pend_i (pend_w),
        .en_i   (src_en_i),
        .any_o  (any_w),
        .idx_o  (pick_w)
    );

    irq_seq_fsm #(
        .N(N), .ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC), .RET_CYC(RET_CYC)
    ) u_fsm (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .any_i            (any_w),
        .idx_i            (pick_w),
        .gie_set_i        (gie_set_i),
        .gie_clr_i        (gie_clr_i),
        .bound_i          (insn_bound_i),
        .busy_i           (multi_busy_i),
        .sleep_i          (sleep_i),
        .reti_i           (reti_i),
        .pc_i             (pc_i),
        .pop_data_i       (pop_data_i),
        .take_o           (take_w),
        .skip_o           (skip_w),
        .win_idx_o        (win_w),
        .gie_o            (gie_o),
        .push_stb_o       (push_stb_o),
        .push_data_o      (push_data_o),
        .pop_stb_o        (pop_stb_o),
        .pc_restore_o     (pc_restore_o),
        .pc_restore_vld_o (pc_restore_vld_o),
        .vec_load_o       (vec_load_o),
        .seq_busy_o       (seq_busy_o)
    );

    assign vec_addr_o = VEC_BASE + (ADDR_W'(win_w) << 1);
endmodule

// File: rtl/irq_sequencer_checker.sv
module irq_sequencer_checker #(
    parameter int N = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         take_i,
    input logic         skip_i,
    input logic         gie_i,
    input logic         gie_clr_i,
    input logic         bound_i,
    input logic [N-1:0] pend_i,
    input logic [N-1:0] en_i,
    input logic         push_i,
    input logic         pop_i,
    input logic         rest_vld_i,
    input logic         busy_i
);
    p_take_enabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> (gie_i && ((pend_i & en_i) != '0)));

    p_take_masks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> !gie_i);

    p_return_unmasks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rest_vld_i && !gie_clr_i) |=> gie_i);

    p_one_insn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (skip_i && bound_i) |-> !take_i);

    p_clr_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gie_clr_i |-> !take_i);

    p_push_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !$past(push_i)) |=> push_i);

    p_pop_pair_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !$past(pop_i)) |=> pop_i);

    p_busy_after_take_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> busy_i);
endmodule

bind irq_sequencer irq_sequencer_checker #(.N(N)) u_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take_w),
    .skip_i     (skip_w),
    .gie_i      (gie_o),
    .gie_clr_i  (gie_clr_i),
    .bound_i    (insn_bound_i),
    .pend_i     (pend_w),
    .en_i       (src_en_i),
    .push_i     (push_stb_o),
    .pop_i      (pop_stb_o),
    .rest_vld_i (pc_restore_vld_o),
    .busy_i     (seq_busy_o)
);

// File: tb/irq_sequencer_bench.sv
`timescale 1ns/1ps
module irq_sequencer_bench;
    localparam logic [7:0] LVL = 8'hC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0, src_en = '0, clr_data = '0;
    logic        clr_wr = 0, gie_set = 0, gie_clr = 0, bound = 0;
    logic        mbusy = 0, sleep = 0, reti = 0;
    logic [15:0] pc = '0;
    logic [7:0]  pop_data;
    logic        push_stb, pop_stb, rest_vld, vec_load, gie, sbusy;
    logic [7:0]  push_data, flags;
    logic [15:0] pc_rest, vec_addr;

    int total = 0, bad = 0;
    logic [7:0] stk [0:15];
    int sp = 0;

    always #2.5 clk = ~clk;

    irq_sequencer u_irq_sequencer (
        .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .src_en_i(src_en),
        .flag_clr_wr_i(clr_wr), .flag_clr_data_i(clr_data), .gie_set_i(gie_set),
        .gie_clr_i(gie_clr), .insn_bound_i(bound), .multi_busy_i(mbusy),
        .sleep_i(sleep), .reti_i(reti), .pc_i(pc), .pop_data_i(pop_data),
        .push_stb_o(push_stb), .push_data_o(push_data), .pop_stb_o(pop_stb),
        .pc_restore_o(pc_rest), .pc_restore_vld_o(rest_vld), .vec_load_o(vec_load),
        .vec_addr_o(vec_addr), .gie_o(gie), .seq_busy_o(sbusy), .flags_o(flags)
    );

    // Byte stack model.
    assign pop_data = (sp > 0) ? stk[sp-1] : 8'h00;
    always @(posedge clk) begin
        if (push_stb) begin
            stk[sp] <= push_data;
            sp <= sp + 1;
        end else if (pop_stb) begin
            sp <= sp - 1;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int src);
        irq_req[src] = 1'b1;
        step();
        irq_req[src] = 1'b0;
        step();
    endtask

    task automatic do_gie_set();
        gie_set = 1'b1;
        step();
        gie_set = 1'b0;
    endtask

    task automatic enter(input logic [15:0] exp_vec, input int exp_k, input string req);
        int got_k = 0, npush = 0;
        logic [15:0] got_vec = '0, pushed = '0;
        logic [15:0] pc_at = pc;
        bound = 1'b1;
        for (int k = 1; k <= 14; k++) begin
            step();
            if (k == 1) begin
                bound = 1'b0;
                chk(sbusy == 1'b1, "R13", sbusy, 1);
                chk(gie == 1'b0, "R2", gie, 0);
            end
            if (push_stb) begin
                if (npush == 0) pushed[7:0] = push_data;
                else pushed[15:8] = push_data;
                npush++;
            end
            if (vec_load && got_k == 0) begin
                got_k = k;
                got_vec = vec_addr;
            end
        end
        chk(got_k == exp_k, (exp_k == 8) ? "R10" : "R9", got_k, exp_k);
        chk(got_vec == exp_vec, req, got_vec, exp_vec);
        chk(pushed == pc_at && npush == 2, "R9", pushed, pc_at);
    endtask

    task automatic do_ret(input logic [15:0] exp_pc);
        int got_k = 0, npop = 0;
        logic [15:0] got_pc = '0;
        logic g5 = 1'b0;
        reti = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            step();
            if (k == 1) reti = 1'b0;
            if (pop_stb) npop++;
            if (rest_vld && got_k == 0) begin
                got_k = k;
                got_pc = pc_rest;
            end
            if (k == 5) g5 = gie;
        end
        chk(got_k == 4 && npop == 2, "R11", got_k, 4);
        chk(got_pc == exp_pc, "R11", got_pc, exp_pc);
        chk(g5 == 1'b1, "R3", g5, 1);
    endtask

    task automatic no_take(input string req);
        int seen = 0;
        bound = 1'b1;
        step();
        bound = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (vec_load || sbusy) seen++;
            step();
        end
        chk(seen == 0, req, seen, 0);
    endtask

    task automatic clear_all();
        clr_wr = 1'b1;
        clr_data = 8'hFF;
        step();
        clr_wr = 1'b0;
        clr_data = '0;
    endtask

    typedef struct packed {
        logic [7:0]  pat;
        logic [7:0]  en;
        logic [15:0] vec;
        logic [7:0]  fl;
    } vec_t;

    localparam vec_t TABLE [6] = '{
        '{pat: 8'b0000_0010, en: 8'hFF,        vec: 16'd2,  fl: 8'h00},
        '{pat: 8'b0010_1000, en: 8'hFF,        vec: 16'd6,  fl: 8'b0010_0000},
        '{pat: 8'b0010_1000, en: 8'b1111_0111, vec: 16'd10, fl: 8'b0000_1000},
        '{pat: 8'b1100_0000, en: 8'hFF,        vec: 16'd12, fl: 8'h00},
        '{pat: 8'b1001_0000, en: 8'b1000_0000, vec: 16'd14, fl: 8'b0001_0000},
        '{pat: 8'b0000_0101, en: 8'hFF,        vec: 16'd4,  fl: 8'h00}
    };

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // Reset state
        chk(gie == 1'b0, "R2", gie, 0);
        chk(flags == 8'h00, "R4", flags, 0);
        chk(!sbusy && !vec_load && !push_stb && !pop_stb, "R13", sbusy, 0);

        // Table walk: priority, vector address, flag residue (R6, R12, R4, R5)
        for (int i = 0; i < 6; i++) begin
            src_en = TABLE[i].en;
            do_gie_set();
            irq_req = TABLE[i].pat;
            step();
            irq_req = TABLE[i].pat & LVL;
            step();
            pc = 16'h1200 + 16'(i * 16'h0111);
            enter(TABLE[i].vec, 4, "R6 R12");
            chk(flags == TABLE[i].fl, "R4", flags, TABLE[i].fl);
            irq_req = '0;
            clear_all();
            do_ret(pc);
            no_take("R7");
        end
        src_en = 8'hFF;

        // R8 and R1: masked flag is held, not taken
        gie_clr = 1'b1;
        step();
        gie_clr = 1'b0;
        chk(gie == 1'b0, "R8", gie, 0);
        pulse(3);
        chk(flags[3] == 1'b1, "R4", flags, 8'h08);
        no_take("R1");
        chk(flags[3] == 1'b1, "R4", flags, 8'h08);
        do_gie_set();
        pc = 16'h0A55;
        enter(16'd6, 4, "R1");
        chk(flags == 8'h00, "R4", flags, 0);

        // R2: nesting after software re-enable
        do_gie_set();
        chk(gie == 1'b1, "R2", gie, 1);
        pulse(1);
        pc = 16'h0BCD;
        enter(16'd2, 4, "R2");
        do_ret(16'h0BCD);
        do_ret(16'h0A55);
        no_take("R7");

        // R7: pending request waits one instruction after return
        pc = 16'h0C01;
        pulse(2);
        enter(16'd4, 4, "R6");
        pulse(4);
        chk(flags[4] == 1'b1, "R4", flags, 8'h10);
        do_ret(16'h0C01);
        no_take("R7");
        pc = 16'h0C77;
        enter(16'd8, 4, "R7");
        do_ret(16'h0C77);
        no_take("R7");

        // R8: disable in the same cycle as a boundary
        pulse(5);
        gie_clr = 1'b1;
        bound = 1'b1;
        step();
        gie_clr = 1'b0;
        bound = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 8; k++) begin
                if (vec_load || sbusy) seen++;
                step();
            end
            chk(seen == 0, "R8", seen, 0);
        end
        chk(gie == 1'b0, "R8", gie, 0);
        chk(flags[5] == 1'b1, "R4", flags, 8'h20);
        clr_wr = 1'b1;
        clr_data = 8'h20;
        step();
        clr_wr = 1'b0;
        clr_data = '0;
        chk(flags == 8'h00, "R4", flags, 0);
        do_gie_set();
        no_take("R4");

        // R5: level request vanishes before enable
        src_en = 8'hBF;
        irq_req[6] = 1'b1;
        step();
        irq_req[6] = 1'b0;
        step();
        src_en = 8'hFF;
        chk(flags == 8'h00, "R5", flags, 0);
        no_take("R5");

        // R9: multi-cycle instruction defers the take
        pulse(1);
        mbusy = 1'b1;
        bound = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 3; k++) begin
                step();
                if (sbusy) seen++;
            end
            chk(seen == 0, "R9", seen, 0);
        end
        mbusy = 1'b0;
        pc = 16'h0D10;
        enter(16'd2, 4, "R9");
        do_ret(16'h0D10);
        no_take("R7");

        // R10: wake from sleep
        sleep = 1'b1;
        pulse(3);
        pc = 16'h0E20;
        enter(16'd6, 8, "R10");
        sleep = 1'b0;
        do_ret(16'h0E20);
        no_take("R7");

        finish_run();
    end
endmodule